// File: doc/BRIEF.md
# Masked Sub-Second Alarm Comparator

This block decides when a real-time clock alarm fires at sub-second resolution. It holds a sub-second compare value and a mask count in one configuration word. On every cycle it compares the compare value with the live value of a synchronous prescaler counter that counts down. The mask count sets how many of the low-order counter bits take part in the comparison, so software can pick a period from every prescaler tick up to one exact sub-second position. A mask count of zero drops the sub-second comparison completely. The alarm then falls back to the seconds-increment strobe.

The comparison of calendar and time fields happens outside this block and arrives as a single match input. The alarm flag is a one-cycle pulse on the rising edge of the combined condition. Configuration writes need the write-protection unlock input. They also need the alarm to be disabled or the clock to be in initialization mode. The configuration survives a system reset and clears only on a backup-domain reset.

Top module: `ssalarm_cmp`

## Requirements
- R1: The read word returns the compare value in bits 14:0 and the mask count in bits 27:24. Bits 31:28 and 23:15 always read as zero, even after a write of all ones to them.
- R2: A write is ignored while the alarm is enabled and the clock is not in initialization mode. A write is accepted while the alarm is disabled or initialization mode is active.
- R3: A write is ignored while the protection unlock input is low.
- R4: With a mask count N from 1 to 15, only counter bits 0 to N-1 are compared with the compare value. A difference in any higher bit does not prevent a match.
- R5: With a mask count of 0, the sub-second condition is the seconds-increment strobe itself.
- R6: Counter bit 15, the overflow bit, never takes part in the comparison.
- R7: The alarm fires only while the external field-match input is high.
- R8: The alarm flag rises one clock after the inputs that first make the combined condition true. It stays high for exactly one cycle, and it does not fire again while the condition stays true.
- R9: No alarm fires while the alarm-enable input is low.
- R10: A backup-domain reset clears the configuration word to zero. A system reset clears the alarm flag and leaves the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bkp_rst_n | input | 1 | Backup-domain reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low; clears the alarm state only |
| wr_en | input | 1 | Configuration write request |
| wr_data | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read word |
| alarm_en | input | 1 | Alarm enable |
| init_mode | input | 1 | Clock is in initialization mode |
| wp_unlock | input | 1 | Write protection is unlocked |
| sub_cnt | input | 16 | Prescaler counter; bit 15 is the overflow bit |
| other_match | input | 1 | Calendar and time fields match |
| sec_tick | input | 1 | Seconds-unit increment strobe |
| alarm_flag | output | 1 | One-cycle alarm pulse |

## Verification
The bench builds the block with its default parameters: a 15-bit compare value, a 4-bit mask count at bit 24 and a 32-bit word. With these values the full-width mask count of 15 can be reached, and so can counter values with the overflow bit set. Mask counts of 0, 1, 4 and 15 are exercised. Each is paired with counter values that differ from the compare value only above the compared bits, or only inside them. This covers the seconds-strobe fallback, the narrowest and widest windows, and the ignored overflow bit.

// File: rtl/ssalarm_pkg.sv
package ssalarm_pkg;

   // Outcome of one configuration write attempt
   typedef enum logic [1:0] {
      WR_NONE   = 2'd0,   // no request this cycle
      WR_TAKE   = 2'd1,   // request accepted
      WR_LOCKED = 2'd2,   // protection still locked
      WR_ARMED  = 2'd3    // alarm running outside initialization
   } wr_verdict_e;

endpackage

// File: rtl/ssalarm_wrgate.sv
module ssalarm_wrgate
   import ssalarm_pkg::*;
(
   input  logic        wr_req,
   input  logic        unlock,
   input  logic        alarm_en,
   input  logic        init_mode,
   output wr_verdict_e verdict
);

   always_comb begin
      if (!wr_req) begin
         verdict = WR_NONE;
      end else if (!unlock) begin
         verdict = WR_LOCKED;
      end else if (alarm_en && !init_mode) begin
         verdict = WR_ARMED;
      end else begin
         verdict = WR_TAKE;
      end
   end

endmodule

// File: rtl/ssalarm_cfg.sv
module ssalarm_cfg #(
   parameter int DW       = 32,
   parameter int SS_W     = 15,
   parameter int MASK_W   = 4,
   parameter int MASK_LSB = 24
) (
   input  logic              clk,
   input  logic              bkp_rst_n,
   input  logic              take,
   input  logic [DW-1:0]     wdata,
   output logic [SS_W-1:0]   val_q,
   output logic [MASK_W-1:0] mask_q,
   output logic [DW-1:0]     rdata
);

   localparam int MASK_MSB = MASK_LSB + MASK_W - 1;

   generate
      if (MASK_LSB < SS_W) begin : g_bad_overlap
         $error("ssalarm_cfg: mask field overlaps compare value");
      end
      if (MASK_MSB >= DW) begin : g_bad_width
         $error("ssalarm_cfg: mask field exceeds word width");
      end
   endgenerate

   // Configuration storage, backup domain only
   always_ff @(posedge clk or negedge bkp_rst_n) begin
      if (!bkp_rst_n) begin
         val_q  <= '0;
         mask_q <= '0;
      end else if (take) begin
         val_q  <= wdata[SS_W-1:0];
         mask_q <= wdata[MASK_MSB:MASK_LSB];
      end
   end

   // Read image assembled bit by bit; reserved positions tie to zero
   for (genvar b = 0; b < DW; b++) begin : g_rd
      if (b < SS_W) begin : g_val
         assign rdata[b] = val_q[b];
      end else if (b >= MASK_LSB && b <= MASK_MSB) begin : g_mask
         assign rdata[b] = mask_q[b-MASK_LSB];
      end else begin : g_rsvd
         assign rdata[b] = 1'b0;
      end
   end

endmodule

// File: rtl/ssalarm_ssmatch.sv
module ssalarm_ssmatch #(
   parameter int SS_W   = 15,
   parameter int MASK_W = 4
) (
   input  logic [MASK_W-1:0] mask_cnt,
   input  logic [SS_W-1:0]   cmp_val,
   input  logic [SS_W-1:0]   cnt_bits,
   input  logic              sec_tick,
   output logic              hit
);

   generate
      if (SS_W > (1 << MASK_W) - 1) begin : g_bad_mask
         $error("ssalarm_ssmatch: mask count too narrow for full compare");
      end
   endgenerate

   logic [SS_W-1:0] care;
   logic [SS_W-1:0] diff;

   // Bit i is compared when the count reaches above it
   for (genvar i = 0; i < SS_W; i++) begin : g_bit
      assign care[i] = (mask_cnt > MASK_W'(i));
      assign diff[i] = care[i] & (cnt_bits[i] ^ cmp_val[i]);
   end

   always_comb begin
      if (mask_cnt == '0) begin
         hit = sec_tick;
      end else begin
         hit = ~|diff;
      end
   end

endmodule

// File: rtl/ssalarm_pulse.sv
module ssalarm_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   output logic pulse
);

   logic cond_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q <= 1'b0;
         pulse  <= 1'b0;
      end else begin
         cond_q <= cond;
         pulse  <= cond & ~cond_q;
      end
   end

endmodule

// File: rtl/ssalarm_cmp.sv
module ssalarm_cmp
   import ssalarm_pkg::*;
#(
   parameter int DW       = 32,
   parameter int SS_W     = 15,
   parameter int MASK_W   = 4,
   parameter int MASK_LSB = 24
) (
   input  logic            clk,
   input  logic            bkp_rst_n,
   input  logic            sys_rst_n,
   input  logic            wr_en,
   input  logic [DW-1:0]   wr_data,
   output logic [DW-1:0]   cfg_rdata,
   input  logic            alarm_en,
   input  logic            init_mode,
   input  logic            wp_unlock,
   input  logic [SS_W:0]   sub_cnt,
   input  logic            other_match,
   input  logic            sec_tick,
   output logic            alarm_flag
);

   localparam int CNT_W = SS_W + 1;

   wr_verdict_e       verdict;
   logic              take;
   logic [SS_W-1:0]   val_q;
   logic [MASK_W-1:0] mask_q;
   logic              ss_hit;
   logic              cond;
   logic              alarm_rst_n;
   logic              cnt_ovf_unused;

   // Overflow bit deliberately excluded from the compare
   assign cnt_ovf_unused = sub_cnt[CNT_W-1];

   ssalarm_wrgate u_gate (
      .wr_req    (wr_en),
      .unlock    (wp_unlock),
      .alarm_en  (alarm_en),
      .init_mode (init_mode),
      .verdict   (verdict)
   );

   assign take = (verdict == WR_TAKE);

   ssalarm_cfg #(
      .DW       (DW),
      .SS_W     (SS_W),
      .MASK_W   (MASK_W),
      .MASK_LSB (MASK_LSB)
   ) u_cfg (
      .clk       (clk),
      .bkp_rst_n (bkp_rst_n),
      .take      (take),
      .wdata     (wr_data),
      .val_q     (val_q),
      .mask_q    (mask_q),
      .rdata     (cfg_rdata)
   );

   ssalarm_ssmatch #(
      .SS_W   (SS_W),
      .MASK_W (MASK_W)
   ) u_match (
      .mask_cnt (mask_q),
      .cmp_val  (val_q),
      .cnt_bits (sub_cnt[SS_W-1:0]),
      .sec_tick (sec_tick),
      .hit      (ss_hit)
   );

   assign cond        = ss_hit & other_match & alarm_en;
   assign alarm_rst_n = bkp_rst_n & sys_rst_n;

   ssalarm_pulse u_pulse (
      .clk   (clk),
      .rst_n (alarm_rst_n),
      .cond  (cond),
      .pulse (alarm_flag)
   );

endmodule

// File: rtl/ssalarm_chk.sv
module ssalarm_chk #(
   parameter int DW       = 32,
   parameter int SS_W     = 15,
   parameter int MASK_W   = 4,
   parameter int MASK_LSB = 24
) (
   input logic          clk,
   input logic          bkp_rst_n,
   input logic          sys_rst_n,
   input logic          wr_en,
   input logic [DW-1:0] cfg_rdata,
   input logic          alarm_en,
   input logic          init_mode,
   input logic          wp_unlock,
   input logic          other_match,
   input logic          alarm_flag
);

   localparam int MASK_END = MASK_LSB + MASK_W;

   // R1: reserved positions of the read word stay zero
   p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!bkp_rst_n)
      (cfg_rdata[DW-1:MASK_END] == '0) && (cfg_rdata[MASK_LSB-1:SS_W] == '0));

   // R2: armed alarm outside initialization blocks writes
   p_wr_armed_r2: assert property (@(posedge clk) disable iff (!bkp_rst_n)
      (wr_en && alarm_en && !init_mode) |=> $stable(cfg_rdata));

   // R3: locked protection blocks writes
   p_wr_locked_r3: assert property (@(posedge clk) disable iff (!bkp_rst_n)
      (!wp_unlock) |=> $stable(cfg_rdata));

   // R7: no alarm without the field match
   p_need_match_r7: assert property (@(posedge clk) disable iff (!bkp_rst_n || !sys_rst_n)
      (!other_match) |=> !alarm_flag);

   // R8: pulse lasts one cycle
   p_one_cycle_r8: assert property (@(posedge clk) disable iff (!bkp_rst_n || !sys_rst_n)
      alarm_flag |=> !alarm_flag);

   // R9: disabled alarm never fires
   p_en_gate_r9: assert property (@(posedge clk) disable iff (!bkp_rst_n || !sys_rst_n)
      (!alarm_en) |=> !alarm_flag);

endmodule

bind ssalarm_cmp ssalarm_chk #(
   .DW       (DW),
   .SS_W     (SS_W),
   .MASK_W   (MASK_W),
   .MASK_LSB (MASK_LSB)
) u_chk (
   .clk         (clk),
   .bkp_rst_n   (bkp_rst_n),
   .sys_rst_n   (sys_rst_n),
   .wr_en       (wr_en),
   .cfg_rdata   (cfg_rdata),
   .alarm_en    (alarm_en),
   .init_mode   (init_mode),
   .wp_unlock   (wp_unlock),
   .other_match (other_match),
   .alarm_flag  (alarm_flag)
);

// File: tb/sim_ssalarm_cmp.sv
`timescale 1ns/1ps
module sim_ssalarm_cmp;

   logic        clk = 1'b0;
   logic        bkp_rst_n = 1'b0;
   logic        sys_rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] cfg_rdata;
   logic        alarm_en = 1'b0;
   logic        init_mode = 1'b0;
   logic        wp_unlock = 1'b0;
   logic [15:0] sub_cnt = '0;
   logic        other_match = 1'b0;
   logic        sec_tick = 1'b0;
   logic        alarm_flag;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Scoreboard queues: expected flag and owning requirement
   bit    exp_q[$];
   string tag_q[$];

   // Bench-side model state
   logic [3:0]  m_mask = '0;
   logic [14:0] m_val  = '0;
   bit          m_prev = 1'b0;

   always #4 clk = ~clk;

   ssalarm_cmp u0 (
      .clk         (clk),
      .bkp_rst_n   (bkp_rst_n),
      .sys_rst_n   (sys_rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .cfg_rdata   (cfg_rdata),
      .alarm_en    (alarm_en),
      .init_mode   (init_mode),
      .wp_unlock   (wp_unlock),
      .sub_cnt     (sub_cnt),
      .other_match (other_match),
      .sec_tick    (sec_tick),
      .alarm_flag  (alarm_flag)
   );

   function automatic bit ss_model(logic [3:0] m, logic [14:0] v, logic [15:0] c, bit t);
      if (m == 4'd0) return t;
      for (int i = 0; i < 15; i++) begin
         if (i < int'(m) && v[i] != c[i]) return 1'b0;
      end
      return 1'b1;
   endfunction

   task automatic check32(string req, logic [31:0] got, logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Monitor: pops one expectation per clock, after the edge
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         bit    e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_cmp++;
         if (alarm_flag !== e) begin
            n_bad++;
            $display("FAIL %s: alarm_flag got %b expected %b", t, alarm_flag, e);
         end
      end
   end

   // Driver: applies one cycle of stimulus and pushes the expected flag
   task automatic step(string req, bit w, logic [31:0] d, bit en, bit ini, bit unl,
                       logic [15:0] cnt, bit oth, bit tick);
      bit cond;
      wr_en = w; wr_data = d; alarm_en = en; init_mode = ini; wp_unlock = unl;
      sub_cnt = cnt; other_match = oth; sec_tick = tick;
      cond = ss_model(m_mask, m_val, cnt, tick) && oth && en;
      exp_q.push_back(cond && !m_prev);
      tag_q.push_back(req);
      m_prev = cond;
      if (w && unl && (!en || ini)) begin
         m_mask = d[27:24];
         m_val  = d[14:0];
      end
      @(negedge clk);
   endtask

   task automatic quiet();
      wr_en = 1'b0; alarm_en = 1'b0; init_mode = 1'b0; wp_unlock = 1'b0;
      sub_cnt = '0; other_match = 1'b0; sec_tick = 1'b0;
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // Reset state (R10)
      repeat (3) @(negedge clk);
      check32("R10 reset word", cfg_rdata, 32'h0);
      check32("R8 reset flag", {31'h0, alarm_flag}, 32'h0);
      bkp_rst_n = 1'b1; sys_rst_n = 1'b1;
      @(negedge clk);

      // R1: all-ones write, reserved bits read back zero
      step("R1", 1, 32'hFFFF_FFFF, 0, 0, 1, 16'h0, 0, 0);
      check32("R1 read image", cfg_rdata, 32'h0F00_7FFF);

      // R3: locked write ignored
      step("R3", 1, 32'h0300_0005, 0, 0, 0, 16'h0, 0, 0);
      check32("R3 locked write", cfg_rdata, 32'h0F00_7FFF);

      // R2: enabled, not init -> ignored; init -> accepted
      step("R2", 1, 32'h0300_0005, 1, 0, 1, 16'h0, 0, 0);
      check32("R2 armed write", cfg_rdata, 32'h0F00_7FFF);
      step("R2", 1, 32'h0F00_1234, 1, 1, 1, 16'h0, 0, 0);
      check32("R2 init write", cfg_rdata, 32'h0F00_1234);

      // R4/R8: full-width compare, single pulse on held match
      step("R4", 0, 0, 1, 0, 0, 16'h1234, 1, 0);
      step("R8", 0, 0, 1, 0, 0, 16'h1234, 1, 0);
      step("R8", 0, 0, 1, 0, 0, 16'h1234, 1, 0);
      step("R4", 0, 0, 1, 0, 0, 16'h1235, 1, 0);
      // R6: overflow bit set still matches
      step("R6", 0, 0, 1, 0, 0, 16'h9234, 1, 0);
      step("R6", 0, 0, 1, 0, 0, 16'h0000, 1, 0);
      // R7: field match low blocks
      step("R7", 0, 0, 1, 0, 0, 16'h1234, 0, 0);
      step("R7", 0, 0, 1, 0, 0, 16'h0000, 0, 0);
      // R9: enable low suppresses
      step("R9", 0, 0, 0, 0, 0, 16'h1234, 1, 0);
      step("R9", 0, 0, 0, 0, 0, 16'h1234, 1, 0);

      // R4: mask 4, value 5
      step("R4", 1, 32'h0400_0005, 0, 0, 1, 16'h0, 0, 0);
      check32("R4 mask4 write", cfg_rdata, 32'h0400_0005);
      step("R4", 0, 0, 1, 0, 0, 16'h7FF5, 1, 0);
      step("R4", 0, 0, 1, 0, 0, 16'h7FF4, 1, 0);
      step("R4", 0, 0, 1, 0, 0, 16'h0015, 1, 0);
      step("R4", 0, 0, 1, 0, 0, 16'h0004, 1, 0);

      // R4: mask 1, value 1
      step("R4", 1, 32'h0100_0001, 0, 0, 1, 16'h0, 0, 0);
      step("R4", 0, 0, 1, 0, 0, 16'h7FFF, 1, 0);
      step("R4", 0, 0, 1, 0, 0, 16'h0002, 1, 0);
      step("R4", 0, 0, 1, 0, 0, 16'h8001, 1, 0);

      // R5: mask 0 follows the seconds strobe
      step("R5", 1, 32'h0000_0ABC, 0, 0, 1, 16'h0, 0, 0);
      check32("R5 mask0 write", cfg_rdata, 32'h0000_0ABC);
      step("R5", 0, 0, 1, 0, 0, 16'h0ABC, 1, 0);
      step("R5", 0, 0, 1, 0, 0, 16'h0123, 1, 1);
      step("R5", 0, 0, 1, 0, 0, 16'h0123, 1, 0);
      step("R5", 0, 0, 1, 0, 0, 16'h0456, 0, 1);
      step("R5", 0, 0, 1, 0, 0, 16'h0456, 1, 0);
      step("R5", 0, 0, 1, 0, 0, 16'h0789, 1, 1);
      step("R5", 0, 0, 1, 0, 0, 16'h0789, 1, 0);

      // R10: system reset keeps configuration, clears flag
      step("R10", 0, 0, 1, 0, 0, 16'h0, 1, 1);
      quiet();
      sys_rst_n = 1'b0;
      m_prev = 1'b0;
      repeat (2) @(negedge clk);
      check32("R10 sys reset flag", {31'h0, alarm_flag}, 32'h0);
      check32("R10 sys reset word", cfg_rdata, 32'h0000_0ABC);
      sys_rst_n = 1'b1;
      @(negedge clk);

      // R10: backup reset clears configuration
      bkp_rst_n = 1'b0;
      m_mask = '0; m_val = '0;
      @(negedge clk);
      check32("R10 backup reset word", cfg_rdata, 32'h0);
      bkp_rst_n = 1'b1;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule